// File: doc/BRIEF.md
# Path-Checked Trace Cache

This block is a two-way set-associative store of instruction traces that sits beside the instruction cache in a fetch stage. Each cycle the fetch unit may present a fetch address together with the directions that the multiple-branch predictor gives for the next three conditional branches. The address alone selects the set and supplies the tag. A stored trace whose tag matches is accepted only when its recorded branch directions agree with the current predictions. On acceptance the block returns up to sixteen instructions with a valid mask, and the address where fetch continues after the trace.

When no tag matches, or a tag matches but the recorded path disagrees with the prediction, the block raises a fallback flag. Fetch then reads the instruction cache and takes its next address from the branch predictor. Results are registered, so a request seen at one clock edge yields its response after that edge. New traces arrive on a separate fill port. A fill reuses the way that already holds the same address, otherwise takes a free way, otherwise replaces the least recently used way of the set.

Top module: `tc_trace_cache`

## Requirements
- R1: A lookup sampled at a rising edge produces exactly one response, with `resp_valid_o` high, in the cycle after that edge. Without a lookup, `resp_valid_o` stays low.
- R2: The set index is `lk_addr_i[OFS_W +: IDX_W]` (bits 5:2 by default) and the tag is every bit above it. The two lowest address bits take no part in the lookup.
- R3: A lookup hits only when a valid way in the set holds the same tag and, for every branch position below that trace's branch count (0 to 3), the stored direction bit equals the predicted bit at that position. Predicted bits at or above the branch count are ignored.
- R4: On a hit, `hit_o` is 1 and `fallback_o` is 0. `instr_o`, `mask_o` and `next_addr_o` equal the instructions, valid mask and next address written by the fill of that trace.
- R5: On a tag miss or a path mismatch, `fallback_o` is 1 and `hit_o` is 0. `instr_o`, `mask_o` and `next_addr_o` are all zero.
- R6: After reset every way is invalid, so every lookup falls back until a fill is made.
- R7: A fill to a new address takes way 0 if it is invalid, otherwise way 1 if it is invalid. Two different tags filled into one set therefore both hit afterwards.
- R8: When both ways of a set are valid, a fill to a new address replaces the least recently used way. Both a fill and a full hit make their way the most recently used.
- R9: A fill whose address already has a valid way in the set overwrites that way. The other way of the set is kept, and later lookups return the new contents.
- R10: A trace filled with branch count 0 hits for any predicted directions.
- R11: A tag match with a path mismatch does not change the replacement order of the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request this cycle |
| lk_addr_i | input | ADDR_W | Fetch address to look up |
| pred_dirs_i | input | 3 | Predicted directions; bit k is the k-th conditional branch, 1 = taken |
| fill_valid_i | input | 1 | Write a trace this cycle |
| fill_addr_i | input | ADDR_W | Start address of the trace being written |
| fill_instr_i | input | MAX_INSTR*INSTR_W | Trace instructions; slot k in bits [k*INSTR_W +: INSTR_W] |
| fill_mask_i | input | MAX_INSTR | Valid bit per instruction slot |
| fill_br_cnt_i | input | 2 | Number of conditional branches in the trace (0 to 3) |
| fill_dirs_i | input | 3 | Recorded direction of each branch, same bit order as the prediction |
| fill_next_i | input | ADDR_W | Fetch address that follows the trace |
| resp_valid_o | output | 1 | Response to the previous cycle's lookup |
| hit_o | output | 1 | Trace supplied |
| fallback_o | output | 1 | Fetch must use the instruction cache path |
| instr_o | output | MAX_INSTR*INSTR_W | Trace instructions on a hit, zero otherwise |
| mask_o | output | MAX_INSTR | Instruction valid mask on a hit, zero otherwise |
| next_addr_o | output | ADDR_W | Stored next fetch address on a hit, zero otherwise |

## Verification
The bench looks for the cases where a tag match must still be rejected. A wrongly predicted first branch must fall back. A trace with two branches must ignore the third predicted bit, and a trace with no branches must accept any prediction. A design that compares all three bits, or none, would return a stale trace or throw away a good one. Replacement is tested with sequences that separate the two ways. A partial hit that refreshes recency would evict the wrong trace. A refill that allocates a duplicate would leave an old copy behind or evict the neighbour. Ignoring the low address bits, or deriving the index from the wrong bits, would show up as a miss on an aligned alias or as a hit in a foreign set.

// File: rtl/tc_pkg.sv
// Shared constants and types for the trace cache.
// Assumes at most three conditional branches per trace and two ways per set.
package tc_pkg;

    localparam int BR_MAX   = 3;
    localparam int BR_CNT_W = 2;
    localparam int WAYS     = 2;

    // Recorded branch path of one stored trace
    typedef struct packed {
        logic [BR_CNT_W-1:0] cnt;
        logic [BR_MAX-1:0]   dirs;
    } path_t;

    // Mask selecting the direction bits that a given branch count makes significant
    function automatic logic [BR_MAX-1:0] path_mask(input logic [BR_CNT_W-1:0] cnt);
        logic [BR_MAX-1:0] m;
        m = '0;
        for (int k = 0; k < BR_MAX; k++) begin
            if (k < int'(cnt)) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/tc_store.sv
// Storage for all ways of the trace cache: valid bits, tags, branch paths and payloads.
// One write port (the fill), one full read port for lookup and a tag-only read
// port used by the fill to find an existing copy. Reads are combinational.
// Assumes the caller never writes and reads the same entry expecting new data in the same cycle.
module tc_store
    import tc_pkg::*;
#(
    parameter int SETS   = 16,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 26,
    parameter int DATA_W = 560
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic                         wr_way,
    input  logic [TAG_W-1:0]             wr_tag,
    input  path_t                        wr_path,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [IDX_W-1:0]             lk_idx,
    output logic [WAYS-1:0]              lk_vld,
    output logic [WAYS-1:0][TAG_W-1:0]   lk_tag,
    output path_t [WAYS-1:0]             lk_path,
    output logic [WAYS-1:0][DATA_W-1:0]  lk_data,
    input  logic [IDX_W-1:0]             pr_idx,
    output logic [WAYS-1:0]              pr_vld,
    output logic [WAYS-1:0][TAG_W-1:0]   pr_tag
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]   vld_q;
        logic [TAG_W-1:0]  tag_q  [SETS];
        path_t             path_q [SETS];
        logic [DATA_W-1:0] data_q [SETS];
        logic              sel;

        assign sel = wr_en && (wr_way == 1'(w));

        // Valid bits: cleared by reset, set by a fill into this way
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= '0;
            end else if (sel) begin
                vld_q[wr_idx] <= 1'b1;
            end
        end

        // Tag, path and payload arrays: written by a fill, no reset needed
        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[wr_idx]  <= wr_tag;
                path_q[wr_idx] <= wr_path;
                data_q[wr_idx] <= wr_data;
            end
        end

        assign lk_vld[w]  = vld_q[lk_idx];
        assign lk_tag[w]  = tag_q[lk_idx];
        assign lk_path[w] = path_q[lk_idx];
        assign lk_data[w] = data_q[lk_idx];
        assign pr_vld[w]  = vld_q[pr_idx];
        assign pr_tag[w]  = tag_q[pr_idx];
    end

endmodule

// File: rtl/tc_way_cmp.sv
// Per-way comparison: a tag match, and agreement between the stored branch path
// and the predicted directions over the first "count" branches only.
// Assumes the prediction bit order matches the stored direction bit order.
module tc_way_cmp
    import tc_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  logic              vld,
    input  logic [TAG_W-1:0]  tag,
    input  logic [TAG_W-1:0]  req_tag,
    input  path_t             path,
    input  logic [BR_MAX-1:0] pred,
    output logic              tag_hit,
    output logic              path_ok
);

    // Combine tag equality with the masked direction check
    always_comb begin
        tag_hit = vld && (tag == req_tag);
        path_ok = ((path.dirs ^ pred) & path_mask(path.cnt)) == '0;
    end

endmodule

// File: rtl/tc_victim.sv
// Chooses the way a fill writes: an existing copy of the same address first,
// then the lowest invalid way, then the least recently used way.
// Assumes at most one way of a set holds a given tag.
module tc_victim
    import tc_pkg::*;
(
    input  logic [WAYS-1:0] vld,
    input  logic [WAYS-1:0] same,
    input  logic            lru_way,
    output logic            way
);

    // Priority selection of the target way
    always_comb begin
        if (same[0])      way = 1'b0;
        else if (same[1]) way = 1'b1;
        else if (!vld[0]) way = 1'b0;
        else if (!vld[1]) way = 1'b1;
        else              way = lru_way;
    end

endmodule

// File: rtl/tc_trace_cache.sv
// Two-way set-associative trace cache with a path check on lookup.
// A lookup indexes by fetch address; a hit needs a tag match and agreement of
// the recorded branch directions with the predictions. Response is registered
// one cycle after the request. A fill writes a complete trace in one cycle.
// Assumes a lookup in the same cycle as a fill to the same set sees the old contents.
module tc_trace_cache
    import tc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int INSTR_W   = 32,
    parameter int MAX_INSTR = 16,
    parameter int ENTRIES   = 32,
    parameter int OFS_W     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         lk_valid_i,
    input  logic [ADDR_W-1:0]            lk_addr_i,
    input  logic [BR_MAX-1:0]            pred_dirs_i,
    input  logic                         fill_valid_i,
    input  logic [ADDR_W-1:0]            fill_addr_i,
    input  logic [MAX_INSTR*INSTR_W-1:0] fill_instr_i,
    input  logic [MAX_INSTR-1:0]         fill_mask_i,
    input  logic [BR_CNT_W-1:0]          fill_br_cnt_i,
    input  logic [BR_MAX-1:0]            fill_dirs_i,
    input  logic [ADDR_W-1:0]            fill_next_i,
    output logic                         resp_valid_o,
    output logic                         hit_o,
    output logic                         fallback_o,
    output logic [MAX_INSTR*INSTR_W-1:0] instr_o,
    output logic [MAX_INSTR-1:0]         mask_o,
    output logic [ADDR_W-1:0]            next_addr_o
);

    localparam int SETS   = ENTRIES / WAYS;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFS_W - IDX_W;
    localparam int IBUS_W = MAX_INSTR * INSTR_W;
    localparam int DATA_W = ADDR_W + MAX_INSTR + IBUS_W;

    logic [IDX_W-1:0] lk_idx, fill_idx;
    logic [TAG_W-1:0] lk_tag, fill_tag;

    assign lk_idx   = lk_addr_i[OFS_W +: IDX_W];
    assign lk_tag   = lk_addr_i[ADDR_W-1 -: TAG_W];
    assign fill_idx = fill_addr_i[OFS_W +: IDX_W];
    assign fill_tag = fill_addr_i[ADDR_W-1 -: TAG_W];

    logic [WAYS-1:0]              rd_vld, pr_vld;
    logic [WAYS-1:0][TAG_W-1:0]   rd_tag, pr_tag;
    path_t [WAYS-1:0]             rd_path;
    logic [WAYS-1:0][DATA_W-1:0]  rd_data;
    logic                         fill_way;
    path_t                        fill_path;

    assign fill_path = '{cnt: fill_br_cnt_i, dirs: fill_dirs_i};

    tc_store #(
        .SETS  (SETS),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (fill_valid_i),
        .wr_idx (fill_idx),
        .wr_way (fill_way),
        .wr_tag (fill_tag),
        .wr_path(fill_path),
        .wr_data({fill_next_i, fill_mask_i, fill_instr_i}),
        .lk_idx (lk_idx),
        .lk_vld (rd_vld),
        .lk_tag (rd_tag),
        .lk_path(rd_path),
        .lk_data(rd_data),
        .pr_idx (fill_idx),
        .pr_vld (pr_vld),
        .pr_tag (pr_tag)
    );

    logic [WAYS-1:0] tag_hit, path_ok, full_hit, fill_same;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        tc_way_cmp #(.TAG_W(TAG_W)) cmp_i (
            .vld    (rd_vld[w]),
            .tag    (rd_tag[w]),
            .req_tag(lk_tag),
            .path   (rd_path[w]),
            .pred   (pred_dirs_i),
            .tag_hit(tag_hit[w]),
            .path_ok(path_ok[w])
        );
        assign full_hit[w]  = tag_hit[w] && path_ok[w];
        assign fill_same[w] = pr_vld[w] && (pr_tag[w] == fill_tag);
    end

    logic any_hit, hit_way;
    assign any_hit = |full_hit;
    assign hit_way = !full_hit[0];

    // One bit per set naming the way to replace next
    logic [SETS-1:0] lru_q;

    tc_victim victim_i (
        .vld    (pr_vld),
        .same   (fill_same),
        .lru_way(lru_q[fill_idx]),
        .way    (fill_way)
    );

    // Replacement order: a full hit, then a fill (which wins), mark their way as recent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            if (lk_valid_i && any_hit) lru_q[lk_idx] <= !hit_way;
            if (fill_valid_i)          lru_q[fill_idx] <= !fill_way;
        end
    end

    logic [DATA_W-1:0] resp_data_q;

    // Registered lookup response; payload cleared whenever fetch must fall back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_o <= 1'b0;
            hit_o        <= 1'b0;
            fallback_o   <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            resp_valid_o <= lk_valid_i;
            hit_o        <= lk_valid_i && any_hit;
            fallback_o   <= lk_valid_i && !any_hit;
            resp_data_q  <= (lk_valid_i && any_hit) ? rd_data[hit_way] : '0;
        end
    end

    assign instr_o     = resp_data_q[IBUS_W-1:0];
    assign mask_o      = resp_data_q[IBUS_W +: MAX_INSTR];
    assign next_addr_o = resp_data_q[DATA_W-1 -: ADDR_W];

endmodule

// File: rtl/tc_trace_cache_chk.sv
// Protocol checks on the trace cache response port, attached by bind.
module tc_trace_cache_chk #(
    parameter int ADDR_W    = 32,
    parameter int MAX_INSTR = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lk_valid_i,
    input logic                 resp_valid_o,
    input logic                 hit_o,
    input logic                 fallback_o,
    input logic [MAX_INSTR-1:0] mask_o,
    input logic [ADDR_W-1:0]    next_addr_o
);

    // R1
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i |=> resp_valid_o);

    // R1
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |=> !resp_valid_o);

    // R4
    hit_xor_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |-> (hit_o != fallback_o));

    // R5
    fallback_payload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fallback_o |-> (mask_o == '0 && next_addr_o == '0));

endmodule

bind tc_trace_cache tc_trace_cache_chk #(
    .ADDR_W   (ADDR_W),
    .MAX_INSTR(MAX_INSTR)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid_i  (lk_valid_i),
    .resp_valid_o(resp_valid_o),
    .hit_o       (hit_o),
    .fallback_o  (fallback_o),
    .mask_o      (mask_o),
    .next_addr_o (next_addr_o)
);

// File: tb/tc_trace_cache_tb_top.sv
// Scoreboard bench: the lookup task queues the expected response, a monitor
// at the falling edge pops and compares each response the design returns.
module tc_trace_cache_tb_top;

    localparam int ADDR_W = 32;
    localparam int INSTR_W = 32;
    localparam int MAX_INSTR = 16;
    localparam int IBUS_W = MAX_INSTR * INSTR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic [2:0] pred = '0;
    logic fill_valid = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [IBUS_W-1:0] fill_instr = '0;
    logic [MAX_INSTR-1:0] fill_mask = '0;
    logic [1:0] fill_cnt = '0;
    logic [2:0] fill_dirs = '0;
    logic [ADDR_W-1:0] fill_next = '0;
    logic resp_valid, hit, fallback;
    logic [IBUS_W-1:0] instr;
    logic [MAX_INSTR-1:0] mask;
    logic [ADDR_W-1:0] next_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit               hit;
        logic [IBUS_W-1:0] instr;
        logic [MAX_INSTR-1:0] mask;
        logic [ADDR_W-1:0] next;
        string            req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    tc_trace_cache dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_valid_i   (lk_valid),
        .lk_addr_i    (lk_addr),
        .pred_dirs_i  (pred),
        .fill_valid_i (fill_valid),
        .fill_addr_i  (fill_addr),
        .fill_instr_i (fill_instr),
        .fill_mask_i  (fill_mask),
        .fill_br_cnt_i(fill_cnt),
        .fill_dirs_i  (fill_dirs),
        .fill_next_i  (fill_next),
        .resp_valid_o (resp_valid),
        .hit_o        (hit),
        .fallback_o   (fallback),
        .instr_o      (instr),
        .mask_o       (mask),
        .next_addr_o  (next_addr)
    );

    function automatic logic [IBUS_W-1:0] mk_instr(input logic [15:0] seed);
        logic [IBUS_W-1:0] v;
        for (int k = 0; k < MAX_INSTR; k++) v[k*INSTR_W +: INSTR_W] = {seed, 16'(k)};
        return v;
    endfunction

    task automatic fill(input logic [ADDR_W-1:0] a, input logic [15:0] seed,
                        input logic [MAX_INSTR-1:0] m, input logic [1:0] c,
                        input logic [2:0] d, input logic [ADDR_W-1:0] nx);
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = a; fill_instr = mk_instr(seed);
        fill_mask = m; fill_cnt = c; fill_dirs = d; fill_next = nx;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Look up an address and queue the expected outcome
    task automatic look(input logic [ADDR_W-1:0] a, input logic [2:0] p, input bit h,
                        input logic [15:0] seed, input logic [MAX_INSTR-1:0] m,
                        input logic [ADDR_W-1:0] nx, input string req);
        exp_t e;
        e.hit = h; e.req = req;
        e.instr = h ? mk_instr(seed) : '0;
        e.mask  = h ? m : '0;
        e.next  = h ? nx : '0;
        @(negedge clk);
        sb.push_back(e);
        lk_valid = 1'b1; lk_addr = a; pred = p;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // Monitor: compare each response against the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected response act=1 exp=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (hit !== e.hit || fallback !== !e.hit || instr !== e.instr ||
                    mask !== e.mask || next_addr !== e.next) begin
                    errors++;
                    $display("FAIL %s act hit=%0b fb=%0b mask=%h next=%h instr=%h exp hit=%0b mask=%h next=%h instr=%h",
                             e.req, hit, fallback, mask, next_addr, instr,
                             e.hit, e.mask, e.next, e.instr);
                end
            end
        end
    end

    localparam logic [ADDR_W-1:0] A = 32'h0000_100C;
    localparam logic [ADDR_W-1:0] B = 32'h0000_200C;
    localparam logic [ADDR_W-1:0] C = 32'h0000_300C;
    localparam logic [ADDR_W-1:0] D = 32'h0000_400C;

    initial begin
        repeat (3) @(negedge clk);
        // Reset state of the response port
        checks++;
        if (resp_valid !== 1'b0 || hit !== 1'b0 || fallback !== 1'b0 || mask !== '0) begin
            errors++;
            $display("FAIL R6 reset outputs act=%0b%0b%0b exp=000", resp_valid, hit, fallback);
        end
        rst_n = 1'b1;

        // R6: empty cache falls back
        look(A, 3'b000, 0, 0, 0, 0, "R6 empty");
        // Trace A: two branches, recorded not-taken/taken pattern dirs[1:0]=01
        fill(A, 16'h0A0A, 16'h00FF, 2'd2, 3'b101, 32'h0000_4000);
        look(A, 3'b001, 1, 16'h0A0A, 16'h00FF, 32'h0000_4000, "R3 R4 path match");
        look(A, 3'b101, 1, 16'h0A0A, 16'h00FF, 32'h0000_4000, "R3 bit above count ignored");
        look(A, 3'b011, 0, 0, 0, 0, "R3 R5 path mismatch");
        look(A, 3'b000, 0, 0, 0, 0, "R5 first branch mismatch");
        // R2: low bits ignored, other index and other tag miss
        look(32'h0000_100E, 3'b001, 1, 16'h0A0A, 16'h00FF, 32'h0000_4000, "R2 low bits");
        look(32'h0000_1010, 3'b001, 0, 0, 0, 0, "R2 other set");
        look(32'h0005_100C, 3'b001, 0, 0, 0, 0, "R2 other tag");
        // R7/R10: second tag in same set, no branches
        fill(B, 16'h0B0B, 16'hFFFF, 2'd0, 3'b111, 32'h0000_8000);
        look(A, 3'b001, 1, 16'h0A0A, 16'h00FF, 32'h0000_4000, "R7 way0 kept");
        look(B, 3'b010, 1, 16'h0B0B, 16'hFFFF, 32'h0000_8000, "R7 R10 any prediction");
        // Order now: B most recent. R11: path-mismatch on A must not refresh A
        look(A, 3'b011, 0, 0, 0, 0, "R11 mismatch");
        fill(C, 16'h0C0C, 16'h0F0F, 2'd1, 3'b001, 32'h0000_C000);
        look(A, 3'b001, 0, 0, 0, 0, "R11 R8 A evicted");
        look(B, 3'b000, 1, 16'h0B0B, 16'hFFFF, 32'h0000_8000, "R8 B kept");
        look(C, 3'b001, 1, 16'h0C0C, 16'h0F0F, 32'h0000_C000, "R8 C hit");
        // B refreshed by this last hit? Order: C then B hit -> make B recent
        look(B, 3'b100, 1, 16'h0B0B, 16'hFFFF, 32'h0000_8000, "R8 B refresh");
        fill(D, 16'h0D0D, 16'h0003, 2'd3, 3'b110, 32'h0000_D000);
        look(C, 3'b001, 0, 0, 0, 0, "R8 C evicted");
        look(B, 3'b000, 1, 16'h0B0B, 16'hFFFF, 32'h0000_8000, "R8 B survives");
        look(D, 3'b110, 1, 16'h0D0D, 16'h0003, 32'h0000_D000, "R8 R3 D full path");
        look(D, 3'b010, 0, 0, 0, 0, "R3 third branch compared");
        // R9: refill B in place, D must stay
        fill(B, 16'h0E0E, 16'h7FFF, 2'd1, 3'b001, 32'h0000_9000);
        look(B, 3'b001, 1, 16'h0E0E, 16'h7FFF, 32'h0000_9000, "R9 new contents");
        look(B, 3'b000, 0, 0, 0, 0, "R9 new path used");
        look(D, 3'b110, 1, 16'h0D0D, 16'h0003, 32'h0000_D000, "R9 neighbour kept");

        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 missing responses act=%0d exp=0", sb.size());
        end
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int cyc = 0; cyc < 20000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=done");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule